// File: doc/BRIEF.md
# Two-Port GPIO Register Bridge with Flash Strobe and Serial-Clock Taps

This block is a small word-addressed register file that controls two general-purpose I/O ports, called port A and port D. Each port has three words: a driven-value word, a sampled-value word and a direction (drive-enable) word. A sampled-value read has no storage of its own behind it. It returns the port's driven value masked by its drive enable, with one external pin folded in. On port A that pin is the ready line of an attached NAND flash. On port D it is the serial output of a bit-banged sensor.

Writing port A's driven-value word also sets the address-latch, command-latch and chip-enable strobes of the flash. Writing port D's driven-value word watches the serial-clock bit. Whenever that bit changes, the block emits a one-cycle edge event for the sensor, carrying the new clock level and the data bit. Every other word in the 92-byte window is plain read/write storage.

Software reaches the block through a single-beat request port with byte enables. Read data returns in the cycle after the request. A write that does not enable all four bytes is dropped and raises an error pulse.

Top module: `gpio_pinbridge_regs`

## Requirements
- R1: After reset, every word reads as zero, all three flash strobes are low, and neither the edge event nor the error pulse is raised.
- R2: A read request (req_valid=1, req_write=0) gives rsp_valid=1 and its data on the clock edge that follows, so both are visible in the next cycle. rsp_valid is low in every cycle that does not follow a read request.
- R3: The word index is req_addr shifted right by two. The two low address bits have no effect on which word is read or written.
- R4: For storage words (every in-window index other than 0x01 and 0x11, including 0x00, 0x02, 0x10 and 0x12), a full write stores all 32 bits and a later read returns them unchanged.
- R5: A read of index 0x01 returns word 0x00 AND word 0x02, with bit 7 ORed with the nand_rdy_i level sampled at the request.
- R6: A read of index 0x11 returns word 0x10 AND word 0x12, with bit 4 ORed with the sens_so_i level sampled at the request.
- R7: After a full write to index 0x00, nand_ale_o equals bit 6 of the written value, nand_cle_o equals bit 5, and nand_ce_o equals bit 4. The strobes change only after such a write.
- R8: A full write to index 0x10 whose bit 1 differs from bit 1 of the stored word raises sclk_evt_o for exactly the next cycle. In that cycle sclk_lvl_o carries the new bit 1 and sclk_din_o carries the new bit 4. A write that leaves bit 1 unchanged raises no event.
- R9: A write with req_be not equal to 4'b1111 changes no word, strobe or event, and raises bus_err for exactly the next cycle. A full write raises no error.
- R10: Indices 23 to 31, which lie beyond the 0x5C-byte window, read as zero, and writes to them have no effect.
- R11: Writing index 0x01 or 0x11 does not change what those indices read. Their read value still follows the masking rule from the other two words of the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address; word index is bits 6:2 |
| req_be | input | 4 | Byte enables; writes need all set |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a partial write |
| nand_rdy_i | input | 1 | Flash ready pin, merged into port A reads |
| sens_so_i | input | 1 | Sensor serial output, merged into port D reads |
| nand_ale_o | output | 1 | Flash address-latch strobe |
| nand_cle_o | output | 1 | Flash command-latch strobe |
| nand_ce_o | output | 1 | Flash chip-enable |
| sclk_evt_o | output | 1 | One-cycle serial-clock edge event |
| sclk_lvl_o | output | 1 | New clock level carried by the event |
| sclk_din_o | output | 1 | Data bit carried by the event |

## Verification
The bench targets several boundaries. The first is the masking of sampled-value reads: a design that forgets the enable mask, or skips the pin merge, reads back raw driven bits or loses the ready or sensor bit. The second is edge detection against the previously stored clock bit. A design that compares against the wrong word, or fires on every write, emits events on repeated levels or misses real toggles. The bench also sends partial-byte writes, which a faulty design would store or use to move the strobes, and addresses beyond the window or with low bits set, which a faulty design would alias onto real words.

// File: rtl/gpio_bridge_pkg.sv
package gpio_bridge_pkg;
   // Word indices whose behaviour differs from plain storage
   localparam int unsigned PA_DRV_IDX = 0;
   localparam int unsigned PA_SMP_IDX = 1;
   localparam int unsigned PA_DIR_IDX = 2;
   localparam int unsigned PD_DRV_IDX = 16;
   localparam int unsigned PD_SMP_IDX = 17;
   localparam int unsigned PD_DIR_IDX = 18;

   typedef struct packed {
      logic ale;
      logic cle;
      logic ce;
   } flash_ctl_t;

   typedef struct packed {
      logic evt;
      logic lvl;
      logic din;
   } clk_edge_t;
endpackage

// File: rtl/gpio_word_store.sv
module gpio_word_store #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 23,
   parameter int unsigned IDX_W     = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_WORDS-1:0][DATA_W-1:0]   words
);
   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            words[g] <= wr_data;
      end
   end
endmodule

// File: rtl/gpio_read_merge.sv
module gpio_read_merge
   import gpio_bridge_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 23,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned RDY_BIT   = 7,
   parameter int unsigned SO_BIT    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic [IDX_W-1:0]                 rd_idx,
   input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
   input  logic                             nand_rdy_i,
   input  logic                             sens_so_i,
   output logic                             rsp_valid,
   output logic [DATA_W-1:0]                rsp_rdata
);
   logic [DATA_W-1:0] stored_sel;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] rdy_vec;
   logic [DATA_W-1:0] so_vec;

   assign rdy_vec = DATA_W'(nand_rdy_i) << RDY_BIT;
   assign so_vec  = DATA_W'(sens_so_i) << SO_BIT;

   // Plain word select; indices beyond the window leave it at zero
   always_comb begin
      stored_sel = '0;
      for (int unsigned i = 0; i < NUM_WORDS; i++)
         if (rd_idx == IDX_W'(i)) stored_sel = words[i];
   end

   always_comb begin
      if (rd_idx == IDX_W'(PA_SMP_IDX))
         merged = (words[PA_DRV_IDX] & words[PA_DIR_IDX]) | rdy_vec;
      else if (rd_idx == IDX_W'(PD_SMP_IDX))
         merged = (words[PD_DRV_IDX] & words[PD_DIR_IDX]) | so_vec;
      else
         merged = stored_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_en;
         if (rd_en) rsp_rdata <= merged;
      end
   end

   // R2: a response always follows a read and only a read
   p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rsp_valid);
   p_rsp_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rsp_valid);
   // R10: out-of-window reads yield zero
   p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(rd_idx) >= int'(NUM_WORDS))) |=> (rsp_rdata == '0));
endmodule

// File: rtl/gpio_strobe_decode.sv
module gpio_strobe_decode
   import gpio_bridge_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 23,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned BE_W      = 4,
   parameter int unsigned SCLK_BIT  = 1,
   parameter int unsigned SDAT_BIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [BE_W-1:0]   acc_be,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              sclk_now,
   output logic              wr_en,
   output clk_edge_t         edge_o,
   output logic              bus_err
);
   logic be_full;
   logic in_window;
   logic toggles;

   assign be_full   = &acc_be;
   assign in_window = int'(acc_idx) < int'(NUM_WORDS);
   assign wr_en     = acc_valid && acc_write && be_full && in_window;
   assign toggles   = wr_en && (acc_idx == IDX_W'(PD_DRV_IDX))
                      && (acc_wdata[SCLK_BIT] != sclk_now);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_o  <= '0;
         bus_err <= 1'b0;
      end else begin
         bus_err    <= acc_valid && acc_write && !be_full;
         edge_o.evt <= toggles;
         if (toggles) begin
            edge_o.lvl <= acc_wdata[SCLK_BIT];
            edge_o.din <= acc_wdata[SDAT_BIT];
         end
      end
   end

   // R9: partial writes flag an error in the next cycle, full writes never do
   p_err_partial_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !be_full) |=> bus_err);
   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write && !be_full) |=> !bus_err);
   // R8: an edge event needs a full write to port D's driven word
   p_evt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o.evt |-> $past(acc_valid && acc_write && be_full
                           && acc_idx == IDX_W'(PD_DRV_IDX)));
   // R8: the event reports a level that differs from the one before the write
   p_evt_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o.evt |-> (edge_o.lvl != $past(sclk_now)));
endmodule

// File: rtl/gpio_pinbridge_regs.sv
module gpio_pinbridge_regs
   import gpio_bridge_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned WINDOW_BYTES = 92,
   parameter int unsigned RDY_BIT      = 7,
   parameter int unsigned SO_BIT       = 4,
   parameter int unsigned ALE_BIT      = 6,
   parameter int unsigned CLE_BIT      = 5,
   parameter int unsigned CE_BIT       = 4,
   parameter int unsigned SCLK_BIT     = 1,
   parameter int unsigned SDAT_BIT     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                bus_err,
   input  logic                nand_rdy_i,
   input  logic                sens_so_i,
   output logic                nand_ale_o,
   output logic                nand_cle_o,
   output logic                nand_ce_o,
   output logic                sclk_evt_o,
   output logic                sclk_lvl_o,
   output logic                sclk_din_o
);
   localparam int unsigned BE_W      = DATA_W / 8;
   localparam int unsigned WORD_B    = DATA_W / 8;
   localparam int unsigned NUM_WORDS = WINDOW_BYTES / WORD_B;
   localparam int unsigned IDX_W     = ADDR_W - 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("bridge expects 32-bit words");
   end
   if (WINDOW_BYTES % WORD_B != 0) begin : g_bad_window
      $error("window must be a whole number of words");
   end
   if (NUM_WORDS > (1 << IDX_W) || NUM_WORDS <= PD_DIR_IDX) begin : g_bad_span
      $error("window does not fit the address or misses port D");
   end
   if (RDY_BIT >= DATA_W || SO_BIT >= DATA_W || ALE_BIT >= DATA_W ||
       CLE_BIT >= DATA_W || CE_BIT >= DATA_W || SCLK_BIT >= DATA_W ||
       SDAT_BIT >= DATA_W) begin : g_bad_bit
      $error("pin bit position outside the word");
   end

   logic [IDX_W-1:0]                 acc_idx;
   logic                             unused_addr_lsb;
   logic                             wr_en;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words;
   clk_edge_t                        edge_q;
   flash_ctl_t                       flash_ctl;

   assign acc_idx         = req_addr[ADDR_W-1:2];
   assign unused_addr_lsb = ^req_addr[1:0];

   gpio_strobe_decode #(
      .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .BE_W(BE_W),
      .SCLK_BIT(SCLK_BIT), .SDAT_BIT(SDAT_BIT)
   ) decode_i (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(req_valid), .acc_write(req_write), .acc_be(req_be),
      .acc_idx(acc_idx), .acc_wdata(req_wdata),
      .sclk_now(words[PD_DRV_IDX][SCLK_BIT]),
      .wr_en(wr_en), .edge_o(edge_q), .bus_err(bus_err)
   );

   gpio_word_store #(
      .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(acc_idx),
      .wr_data(req_wdata), .words(words)
   );

   gpio_read_merge #(
      .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
      .RDY_BIT(RDY_BIT), .SO_BIT(SO_BIT)
   ) merge_i (
      .clk(clk), .rst_n(rst_n), .rd_en(req_valid && !req_write),
      .rd_idx(acc_idx), .words(words), .nand_rdy_i(nand_rdy_i),
      .sens_so_i(sens_so_i), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   // Flash strobes follow the stored driven word of port A
   assign flash_ctl.ale = words[PA_DRV_IDX][ALE_BIT];
   assign flash_ctl.cle = words[PA_DRV_IDX][CLE_BIT];
   assign flash_ctl.ce  = words[PA_DRV_IDX][CE_BIT];
   assign nand_ale_o    = flash_ctl.ale;
   assign nand_cle_o    = flash_ctl.cle;
   assign nand_ce_o     = flash_ctl.ce;

   assign sclk_evt_o = edge_q.evt;
   assign sclk_lvl_o = edge_q.lvl;
   assign sclk_din_o = edge_q.din;

   // R7: strobes hold whenever no write is presented
   p_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable({nand_ale_o, nand_cle_o, nand_ce_o}));
   // R9: a partial write never moves the strobes
   p_partial_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !(&req_be)) |=>
         $stable({nand_ale_o, nand_cle_o, nand_ce_o}));
endmodule

// File: tb/gpio_pinbridge_regs_tb.sv
module gpio_pinbridge_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, bus_err;
   logic [31:0] rsp_rdata;
   logic        nand_rdy_i = 1'b0, sens_so_i = 1'b0;
   logic        nand_ale_o, nand_cle_o, nand_ce_o;
   logic        sclk_evt_o, sclk_lvl_o, sclk_din_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [0:31];

   always #2 clk = ~clk;

   gpio_pinbridge_regs dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_err(bus_err),
      .nand_rdy_i(nand_rdy_i), .sens_so_i(sens_so_i),
      .nand_ale_o(nand_ale_o), .nand_cle_o(nand_cle_o), .nand_ce_o(nand_ce_o),
      .sclk_evt_o(sclk_evt_o), .sclk_lvl_o(sclk_lvl_o), .sclk_din_o(sclk_din_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [4:0] idx, input logic rdy, input logic so);
      if (idx >= 5'd23) return 32'h0;                                    // R10
      if (idx == 5'd1)  return (model[0] & model[2]) | (32'(rdy) << 7);  // R5
      if (idx == 5'd17) return (model[16] & model[18]) | (32'(so) << 4); // R6
      return model[idx];                                                 // R4
   endfunction

   task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be, input string req);
      logic [4:0] idx = a[6:2];
      logic full = (be == 4'hF);
      logic ok = full && (idx < 5'd23);
      logic ev = ok && (idx == 5'd16) && (model[16][1] != d[1]);
      if (ok) model[idx] = d;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk({req, " err"}, 32'(bus_err), 32'(!full));
      chk({req, " evt"}, 32'(sclk_evt_o), 32'(ev));
      if (ev) chk({req, " evt lvl/din"}, {30'd0, sclk_lvl_o, sclk_din_o}, {30'd0, d[1], d[4]});
      chk({req, " strobes R7"}, {29'd0, nand_ale_o, nand_cle_o, nand_ce_o},
          {29'd0, model[0][6], model[0][5], model[0][4]});
   endtask

   task automatic rd(input logic [6:0] a, input logic rdy, input logic so, input string req);
      logic [31:0] e = exp_read(a[6:2], rdy, so);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = $urandom_range(0, 15);
      nand_rdy_i = rdy; sens_so_i = so;
      @(negedge clk);
      req_valid = 1'b0;
      chk({req, " rsp_valid R2"}, 32'(rsp_valid), 32'd1);
      chk({req, " rdata"}, rsp_rdata, e);
      @(negedge clk);
      chk({req, " rsp_valid drop R2"}, 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 strobes", {29'd0, nand_ale_o, nand_cle_o, nand_ce_o}, 32'd0);
      chk("R1 evt/err", {30'd0, sclk_evt_o, bus_err}, 32'd0);
      chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      rd(7'h00, 1'b0, 1'b0, "R1 word0");
      rd(7'h48, 1'b0, 1'b0, "R1 word18");
      rd(7'h04, 1'b1, 1'b0, "R5 reset ready");
      // R7 strobe decode
      wr(7'h00, 32'h0000_0070, 4'hF, "R7 all strobes");
      wr(7'h00, 32'h0000_0040, 4'hF, "R7 ale only");
      wr(7'h00, 32'h0000_0020, 4'hF, "R7 cle only");
      wr(7'h00, 32'hFFFF_FF90, 4'hF, "R7 ce only");
      // R5 masking
      wr(7'h08, 32'h0F0F_00F0, 4'hF, "R4 dir A");
      rd(7'h04, 1'b0, 1'b0, "R5 mask");
      rd(7'h04, 1'b1, 1'b1, "R5 ready merge");
      // R8 edges
      wr(7'h40, 32'h0000_0012, 4'hF, "R8 rise din1");
      wr(7'h40, 32'h0000_0002, 4'hF, "R8 same level");
      wr(7'h40, 32'h0000_0010, 4'hF, "R8 fall din1");
      wr(7'h40, 32'hFFFF_FFED, 4'hF, "R8 no toggle");
      // R6 masking
      wr(7'h48, 32'h0000_FF00, 4'hF, "R4 dir D");
      rd(7'h44, 1'b0, 1'b1, "R6 sensor merge");
      rd(7'h44, 1'b0, 1'b0, "R6 mask");
      // R9 partial writes
      wr(7'h00, 32'h0000_0000, 4'h7, "R9 partial A");
      wr(7'h40, 32'h0000_0002, 4'hE, "R9 partial D");
      rd(7'h00, 1'b0, 1'b0, "R9 unchanged");
      // R3 low bits, R10 window, R11 sampled-word writes
      wr(7'h0F, 32'hCAFE_0001, 4'hF, "R3 low bits");
      rd(7'h0C, 1'b0, 1'b0, "R3 readback");
      rd(7'h0E, 1'b0, 1'b0, "R3 alias read");
      wr(7'h5C, 32'hDEAD_BEEF, 4'hF, "R10 oob write");
      rd(7'h5C, 1'b0, 1'b0, "R10 oob read");
      rd(7'h7C, 1'b0, 1'b0, "R10 top read");
      wr(7'h04, 32'hFFFF_FFFF, 4'hF, "R11 write A smp");
      rd(7'h04, 1'b0, 1'b0, "R11 A smp");
      wr(7'h44, 32'hFFFF_FFFF, 4'hF, "R11 write D smp");
      rd(7'h44, 1'b1, 1'b0, "R11 D smp");
      // Random mix
      for (int n = 0; n < 500; n++) begin
         logic [6:0] a;
         int pick = $urandom_range(0, 9);
         case (pick)
            0: a = 7'h00; 1: a = 7'h04; 2: a = 7'h08;
            3: a = 7'h40; 4: a = 7'h44; 5: a = 7'h48;
            default: a = 7'($urandom_range(0, 127));
         endcase
         if ($urandom_range(0, 1) == 1) begin
            logic [3:0] be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            wr(a, $urandom, be, "R4/R8/R9 random write");
         end else begin
            rd(a, 1'($urandom), 1'($urandom), "R4/R5/R6 random read");
         end
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule